// File: doc/BRIEF.md
# Quadrature Up/Down Timer with Compare and Buffered Capture

This block is a parameterised up/down counter driven from two external pins. In clock/direction mode, every transition of the clock pin moves the count by one, and the second pin sets which way it moves. In encoder mode, the two pins are read as a pair of signals a quarter phase apart. Every legal transition of the pair moves the count by one, and the order of the phases sets the direction. Each pin is resynchronised to the system clock before its edges are detected. Software can load the counter directly.

A compare register sits beside the counter. A match is reported only when the counter steps onto the compare value. When reset-on-match is enabled, that match clears the counter. A capture pin with selectable edges copies the current count into a two-entry buffer. Reads take the oldest entry first. When both entries are full, further captures are dropped and flagged. Sticky flags report counter wrap, capture overrun, and a reset-on-match that landed in the same cycle as a software load.

Top module: `qtimer_cc`

## Requirements
- R1: After synchronous reset, the count, the compare register, the capture buffer and all flags are zero, and `cap_valid` is low.
- R2: With `quad_mode`=0, every rising and every falling transition of `ext_clk` moves the count by exactly one. The counter updates on the third rising system-clock edge after the pin changes. A change on `ext_dir` alone moves nothing.
- R3: With `quad_mode`=0, the count increments when `ext_dir` is 1 and decrements when it is 0.
- R4: A `load_en` pulse writes `load_val` into the counter on the next edge. A load never raises `match_pulse`, even when the loaded value equals the compare register.
- R5: `match_pulse` is high for one cycle when a counting step, in either direction, lands on the compare register value.
- R6: With `cmp_reset_en`=1, a match clears the counter to zero instead of leaving it at the compare value, and it still gives a single `match_pulse`.
- R7: A count that reaches zero through a load or a reset-on-match, with the compare register at zero, gives no `match_pulse`.
- R8: `ovf_flag` is set when an increment wraps the count from all ones to zero, or a decrement wraps it from zero to all ones. The flag stays set until `flag_clr`.
- R9: When a reset-on-match and `load_en` fall in the same cycle, the counter becomes zero and `conflict_flag` is set. The flag stays set until `flag_clr`.
- R10: With `quad_mode`=1, the pair {`ext_clk`,`ext_dir`} stepping through 00,10,11,01,00 counts up by one per transition. The reverse order counts down. A transition where both pins change at once is ignored.
- R11: `cap_edge_sel` bit 0 enables capture on a rising edge of `cap_in`, and bit 1 enables capture on a falling edge. A capture stores the count held at that moment.
- R12: The capture buffer holds two entries and reads return the oldest first. A `cap_rd` while `cap_valid` is high removes the shown entry. A capture arriving while both entries are full is discarded and sets `overrun_flag` until `flag_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| quad_mode | input | 1 | 0: clock/direction counting, 1: encoder counting |
| ext_clk | input | 1 | External count clock, or encoder phase A |
| ext_dir | input | 1 | Count direction, or encoder phase B |
| cap_in | input | 1 | Capture event pin |
| cap_edge_sel | input | 2 | Bit 0 rising, bit 1 falling capture enable |
| load_en | input | 1 | Software load strobe |
| load_val | input | CNT_W | Value to load |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | CNT_W | Compare register write data |
| cmp_reset_en | input | 1 | Clear the counter on a match |
| cap_rd | input | 1 | Pop the oldest capture entry |
| flag_clr | input | 1 | Clear sticky flags |
| count | output | CNT_W | Current count |
| cmp_value | output | CNT_W | Compare register contents |
| cap_data | output | CNT_W | Oldest capture entry |
| cap_valid | output | 1 | Capture buffer is not empty |
| match_pulse | output | 1 | One-cycle compare match |
| ovf_flag | output | 1 | Sticky wrap flag |
| overrun_flag | output | 1 | Sticky capture overrun flag |
| conflict_flag | output | 1 | Sticky reset/load collision flag |

## Verification
The bench uses the default parameters: a 16-bit counter and a two-stage synchroniser. With these values, the three-edge input latency is a fixed wait the bench can schedule exactly. Both wrap boundaries are reached by loading 0xFFFF or zero and taking a single step. The 16-bit width keeps capture values distinct enough that an entry returned out of order, or a discarded entry reappearing, shows up in the scoreboard comparison.

// File: rtl/qtc_pkg.sv
package qtc_pkg;

    localparam int CNT_W_DEF   = 16;
    localparam int SYNC_DEF    = 2;
    localparam int CAP_DEPTH   = 2;

    typedef enum logic {
        MODE_CLKDIR = 1'b0,
        MODE_QUAD   = 1'b1
    } qtc_mode_e;

    typedef struct packed {
        logic step;
        logic up;
    } qtc_step_t;

    // Encoder direction: phase A leading phase B gives an up step.
    function automatic logic quad_is_up(logic a_now, logic b_prev);
        return a_now ^ b_prev;
    endfunction

endpackage

// File: rtl/qtc_sync.sv
module qtc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/qtc_decode.sv
module qtc_decode
    import qtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  qtc_mode_e mode,
    input  logic      a_s,
    input  logic      b_s,
    output qtc_step_t step_o
);
    logic a_p, b_p;
    logic da, db;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_p <= 1'b0;
            b_p <= 1'b0;
        end else begin
            a_p <= a_s;
            b_p <= b_s;
        end
    end

    assign da = a_s ^ a_p;
    assign db = b_s ^ b_p;

    always_comb begin
        if (mode == MODE_QUAD) begin
            step_o.step = da ^ db;
            step_o.up   = quad_is_up(a_s, b_p);
        end else begin
            step_o.step = da;
            step_o.up   = b_s;
        end
    end
endmodule

// File: rtl/qtc_counter.sv
module qtc_counter
    import qtc_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  qtc_step_t        step_i,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             cmp_reset_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             match_pulse,
    output logic             ovf_flag,
    output logic             conflict_flag
);
    logic [CNT_W-1:0] cnt_next;
    logic             hit;
    logic             hit_rst;
    logic             wrap;
    logic             step_taken;

    always_comb begin
        cnt_next   = step_i.up ? CNT_W'(cnt_q + 1'b1) : CNT_W'(cnt_q - 1'b1);
        hit        = step_i.step && (cnt_next == cmp_q);
        hit_rst    = hit && cmp_reset_en;
        wrap       = step_i.up ? (cnt_q == '1) : (cnt_q == '0);
        step_taken = step_i.step && (hit_rst || !load_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q         <= '0;
            cmp_q         <= '0;
            match_pulse   <= 1'b0;
            ovf_flag      <= 1'b0;
            conflict_flag <= 1'b0;
        end else begin
            if (cmp_wr) cmp_q <= cmp_wdata;
            match_pulse <= 1'b0;
            if (hit_rst) begin
                cnt_q       <= '0;
                match_pulse <= 1'b1;
            end else if (load_en) begin
                cnt_q <= load_val;
            end else if (step_i.step) begin
                cnt_q       <= cnt_next;
                match_pulse <= hit;
            end
            ovf_flag      <= (ovf_flag && !flag_clr) || (step_taken && wrap);
            conflict_flag <= (conflict_flag && !flag_clr) || (hit_rst && load_en);
        end
    end

    AST_LOAD_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
        load_en && !cmp_reset_en |=> !match_pulse);  // R4

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> (cnt_q == $past(cnt_q)) || (cnt_q == '0)
                     || (cnt_q == CNT_W'($past(cnt_q) + 1'b1))
                     || (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));  // R2

    AST_MATCH_VALUE: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> (cnt_q == $past(cmp_q))
                        || ((cnt_q == '0) && $past(cmp_reset_en)));  // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_flag && !flag_clr |=> ovf_flag);  // R8

    AST_CONFLICT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(conflict_flag) |-> cnt_q == '0);  // R9
endmodule

// File: rtl/qtc_capture.sv
module qtc_capture
    import qtc_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_s,
    input  logic [1:0]       edge_sel,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             rd,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_data,
    output logic             cap_valid,
    output logic             overrun_flag
);
    logic [CNT_W-1:0]     stg   [CAP_DEPTH];
    logic [CNT_W-1:0]     stg_n [CAP_DEPTH];
    logic [CAP_DEPTH-1:0] vld, vld_n;
    logic                 cap_p;
    logic                 ev;
    logic                 ovr_set;

    assign ev = (cap_s & ~cap_p & edge_sel[0]) | (~cap_s & cap_p & edge_sel[1]);

    always_comb begin
        stg_n   = stg;
        vld_n   = vld;
        ovr_set = 1'b0;
        if (rd && vld[0]) begin
            for (int i = 0; i < CAP_DEPTH - 1; i++) begin
                stg_n[i] = stg[i+1];
                vld_n[i] = vld[i+1];
            end
            vld_n[CAP_DEPTH-1] = 1'b0;
        end
        if (ev) begin
            if (vld_n[0] == 1'b0) begin
                stg_n[0] = cnt_val;
                vld_n[0] = 1'b1;
            end else if (vld_n[1] == 1'b0) begin
                stg_n[1] = cnt_val;
                vld_n[1] = 1'b1;
            end else begin
                ovr_set = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CAP_DEPTH; i++) stg[i] <= '0;
            vld          <= '0;
            cap_p        <= 1'b0;
            overrun_flag <= 1'b0;
        end else begin
            stg          <= stg_n;
            vld          <= vld_n;
            cap_p        <= cap_s;
            overrun_flag <= (overrun_flag && !flag_clr) || ovr_set;
        end
    end

    assign cap_data  = stg[0];
    assign cap_valid = vld[0];

    AST_FILL_ORDER: assert property (@(posedge clk) disable iff (rst)
        vld[1] |-> vld[0]);  // R12

    AST_OVERRUN_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_flag) |-> $past(vld) == 2'b11);  // R12
endmodule

// File: rtl/qtimer_cc.sv
module qtimer_cc
    import qtc_pkg::*;
#(
    parameter int CNT_W       = CNT_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             quad_mode,
    input  logic             ext_clk,
    input  logic             ext_dir,
    input  logic             cap_in,
    input  logic [1:0]       cap_edge_sel,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             cmp_reset_en,
    input  logic             cap_rd,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cmp_value,
    output logic [CNT_W-1:0] cap_data,
    output logic             cap_valid,
    output logic             match_pulse,
    output logic             ovf_flag,
    output logic             overrun_flag,
    output logic             conflict_flag
);
    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_s;
    qtc_step_t        step;
    qtc_mode_e        mode;

    assign mode = quad_mode ? MODE_QUAD : MODE_CLKDIR;

    qtc_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cap_in, ext_dir, ext_clk}),
        .q   (pins_s)
    );

    qtc_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .a_s    (pins_s[0]),
        .b_s    (pins_s[1]),
        .step_o (step)
    );

    qtc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst           (rst),
        .step_i        (step),
        .load_en       (load_en),
        .load_val      (load_val),
        .cmp_wr        (cmp_wr),
        .cmp_wdata     (cmp_wdata),
        .cmp_reset_en  (cmp_reset_en),
        .flag_clr      (flag_clr),
        .cnt_q         (count),
        .cmp_q         (cmp_value),
        .match_pulse   (match_pulse),
        .ovf_flag      (ovf_flag),
        .conflict_flag (conflict_flag)
    );

    qtc_capture #(.CNT_W(CNT_W)) u_cap (
        .clk          (clk),
        .rst          (rst),
        .cap_s        (pins_s[2]),
        .edge_sel     (cap_edge_sel),
        .cnt_val      (count),
        .rd           (cap_rd),
        .flag_clr     (flag_clr),
        .cap_data     (cap_data),
        .cap_valid    (cap_valid),
        .overrun_flag (overrun_flag)
    );
endmodule

// File: tb/sim_qtimer_cc.sv
module sim_qtimer_cc;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         quad_mode = 1'b0;
    logic         ext_clk = 1'b0;
    logic         ext_dir = 1'b1;
    logic         cap_in = 1'b0;
    logic [1:0]   cap_edge_sel = 2'b01;
    logic         load_en = 1'b0;
    logic [W-1:0] load_val = '0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         cmp_reset_en = 1'b0;
    logic         cap_rd = 1'b0;
    logic         flag_clr = 1'b0;
    logic [W-1:0] count, cmp_value, cap_data;
    logic         cap_valid, match_pulse, ovf_flag, overrun_flag, conflict_flag;

    int checks = 0;
    int failures = 0;
    int match_seen = 0;
    bit finished = 1'b0;
    logic [W-1:0] exp_q [$];

    always #5 clk = ~clk;

    qtimer_cc u0 (
        .clk(clk), .rst(rst), .quad_mode(quad_mode), .ext_clk(ext_clk),
        .ext_dir(ext_dir), .cap_in(cap_in), .cap_edge_sel(cap_edge_sel),
        .load_en(load_en), .load_val(load_val), .cmp_wr(cmp_wr),
        .cmp_wdata(cmp_wdata), .cmp_reset_en(cmp_reset_en), .cap_rd(cap_rd),
        .flag_clr(flag_clr), .count(count), .cmp_value(cmp_value),
        .cap_data(cap_data), .cap_valid(cap_valid), .match_pulse(match_pulse),
        .ovf_flag(ovf_flag), .overrun_flag(overrun_flag),
        .conflict_flag(conflict_flag)
    );

    // Pulse counter for match_pulse, sampled at the falling edge.
    always @(negedge clk) if (!rst && match_pulse) match_seen++;

    // Capture monitor: pops the scoreboard when a read is presented.
    always @(negedge clk) begin
        #3;
        if (!rst && cap_rd && cap_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R12: actual=%h expected=<empty scoreboard>", cap_data);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                if (cap_data !== e) begin
                    failures++;
                    $display("FAIL R11/R12 capture: actual=%h expected=%h", cap_data, e);
                end
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    task automatic tick(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(logic [W-1:0] v);
        load_val = v; load_en = 1'b1;
        tick(1);
        load_en = 1'b0;
    endtask

    task automatic do_cmp(logic [W-1:0] v);
        cmp_wdata = v; cmp_wr = 1'b1;
        tick(1);
        cmp_wr = 1'b0;
    endtask

    task automatic toggle_clk();
        ext_clk = ~ext_clk;
        tick(4);
    endtask

    task automatic clear_flags();
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
    endtask

    task automatic quad_to(logic a, logic b);
        ext_clk = a; ext_dir = b;
        tick(4);
    endtask

    task automatic cap_drive(logic v, bit expect_store);
        if (expect_store) exp_q.push_back(count);
        cap_in = v;
        tick(4);
    endtask

    task automatic cap_read();
        cap_rd = 1'b1;
        tick(1);
        cap_rd = 1'b0;
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        // R1 reset state
        chk("R1 count", count, 16'h0000);
        chk("R1 cmp", cmp_value, 16'h0000);
        chk("R1 cap_valid", {15'd0, cap_valid}, 16'h0000);
        chk("R1 flags", {12'd0, ovf_flag, overrun_flag, conflict_flag, match_pulse}, 16'h0000);

        // R2 both edges count, direction up
        for (int i = 0; i < 6; i++) toggle_clk();
        chk("R2 both edges", count, 16'd6);
        ext_dir = 1'b0;
        tick(4);
        chk("R2 direction change alone", count, 16'd6);
        // R3 direction low decrements
        toggle_clk();
        toggle_clk();
        chk("R3 count down", count, 16'd4);

        // R4 load equal to compare gives no match
        do_cmp(16'h1234);
        do_load(16'h1234);
        tick(4);
        chk("R4 load value", count, 16'h1234);
        chk("R4 no match on load", 16'(match_seen), 16'd0);

        // R5 step down onto compare, then up onto compare
        do_load(16'h1235);
        toggle_clk();
        chk("R5 down count", count, 16'h1234);
        chk("R5 match down", 16'(match_seen), 16'd1);
        ext_dir = 1'b1;
        do_load(16'h1232);
        toggle_clk();
        chk("R5 no early match", 16'(match_seen), 16'd1);
        toggle_clk();
        chk("R5 match up", 16'(match_seen), 16'd2);

        // R6 reset on match
        cmp_reset_en = 1'b1;
        do_cmp(16'd5);
        do_load(16'd3);
        toggle_clk();
        chk("R6 pre-match", count, 16'd4);
        toggle_clk();
        chk("R6 cleared", count, 16'd0);
        tick(6);
        chk("R6 single match", 16'(match_seen), 16'd3);

        // R7 zero reached by load with compare at zero
        do_cmp(16'd0);
        do_load(16'd7);
        do_load(16'd0);
        tick(4);
        chk("R7 no match at zero", 16'(match_seen), 16'd3);

        // R8 wrap both directions
        cmp_reset_en = 1'b0;
        do_cmp(16'h8000);
        do_load(16'hFFFF);
        chk("R8 flag clear before wrap", {15'd0, ovf_flag}, 16'd0);
        toggle_clk();
        chk("R8 wrap up value", count, 16'h0000);
        chk("R8 wrap up flag", {15'd0, ovf_flag}, 16'd1);
        tick(3);
        chk("R8 flag sticky", {15'd0, ovf_flag}, 16'd1);
        clear_flags();
        chk("R8 flag cleared", {15'd0, ovf_flag}, 16'd0);
        ext_dir = 1'b0;
        do_load(16'h0000);
        toggle_clk();
        chk("R8 wrap down value", count, 16'hFFFF);
        chk("R8 wrap down flag", {15'd0, ovf_flag}, 16'd1);
        clear_flags();

        // R9 reset-on-match collides with load
        ext_dir = 1'b1;
        cmp_reset_en = 1'b1;
        do_cmp(16'd5);
        do_load(16'd4);
        ext_clk = ~ext_clk;
        tick(2);
        load_val = 16'h0777; load_en = 1'b1;
        tick(1);
        load_en = 1'b0;
        tick(1);
        chk("R9 reset wins", count, 16'd0);
        chk("R9 conflict flag", {15'd0, conflict_flag}, 16'd1);
        chk("R9 match counted", 16'(match_seen), 16'd4);
        clear_flags();
        chk("R9 conflict cleared", {15'd0, conflict_flag}, 16'd0);

        // R10 encoder mode
        cmp_reset_en = 1'b0;
        do_cmp(16'h8000);
        ext_clk = 1'b0; ext_dir = 1'b0;
        tick(4);
        do_load(16'h0100);
        quad_mode = 1'b1;
        tick(4);
        chk("R10 mode entry", count, 16'h0100);
        quad_to(1'b1, 1'b0);
        quad_to(1'b1, 1'b1);
        quad_to(1'b0, 1'b1);
        quad_to(1'b0, 1'b0);
        chk("R10 forward", count, 16'h0104);
        quad_to(1'b0, 1'b1);
        quad_to(1'b1, 1'b1);
        quad_to(1'b1, 1'b0);
        quad_to(1'b0, 1'b0);
        chk("R10 reverse", count, 16'h0100);
        quad_to(1'b1, 1'b1);
        quad_to(1'b0, 1'b0);
        chk("R10 double change ignored", count, 16'h0100);
        quad_mode = 1'b0;
        tick(2);

        // R11 rising-edge capture, R12 two-deep buffer
        cap_edge_sel = 2'b01;
        do_load(16'h0100);
        cap_drive(1'b1, 1'b1);
        chk("R11 valid after capture", {15'd0, cap_valid}, 16'd1);
        do_load(16'h0200);
        cap_drive(1'b0, 1'b0);
        cap_drive(1'b1, 1'b1);
        chk("R12 no overrun with two", {15'd0, overrun_flag}, 16'd0);
        do_load(16'h0300);
        cap_drive(1'b0, 1'b0);
        cap_drive(1'b1, 1'b0);
        chk("R12 overrun set", {15'd0, overrun_flag}, 16'd1);
        cap_read();
        cap_read();
        tick(1);
        chk("R12 buffer drained", {15'd0, cap_valid}, 16'd0);
        chk("R12 scoreboard empty", 16'(exp_q.size()), 16'd0);
        clear_flags();
        chk("R12 overrun cleared", {15'd0, overrun_flag}, 16'd0);

        // R11 falling-edge capture
        cap_edge_sel = 2'b10;
        do_load(16'h0ABC);
        cap_drive(1'b0, 1'b1);
        chk("R11 falling capture valid", {15'd0, cap_valid}, 16'd1);
        cap_read();
        tick(1);
        chk("R11 falling drained", {15'd0, cap_valid}, 16'd0);
        chk("R11 scoreboard empty", 16'(exp_q.size()), 16'd0);

        tick(2);
        summary();
    end
endmodule